// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one whole instruction per clock. In one cycle it fetches the word at the program counter, decodes it, reads two registers, runs the ALU, optionally touches data memory, and writes the result back. It handles a small load/store subset: register-to-register arithmetic and logic, word load, word store, and branch-if-equal. Branches are relative to the program counter. Loads and stores add a signed offset to a base register.

Both memories are internal arrays addressed by word. A load port writes program words into instruction memory and initial values into data memory, and it works only while the core is held in reset. Four debug outputs show the current byte PC, the current instruction, the ALU result and the value selected for write-back.

Top module: `onecycle_cpu`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the PC becomes 0. After release, the first instruction executed is instruction word 0, and `dbg_pc` reads 0 until that edge.
- R2: An instruction that is not a taken branch advances the byte PC by 4, i.e. the 8-bit word PC by one.
- R3: With `rst_n` low and `load_en` high at a rising edge, `load_data` is written to word `load_addr`: into data memory if `load_dmem` is 1, otherwise into instruction memory. The instruction memory holds 256 words of 32 bits. While `rst_n` is high, the load port has no effect.
- R4: The opcode is bits [31:26]. 000000 is register format, 100011 is word load, 101011 is word store and 000100 is branch-if-equal. Any other opcode writes neither a register nor memory, and it advances the PC by 4.
- R5: Branch-if-equal compares register rs (bits [25:21]) with register rt (bits [20:16]). When they are equal, the next byte PC is PC+4 plus the sign-extended 16-bit offset (bits [15:0]) shifted left by 2. When they differ, the next byte PC is PC+4.
- R6: Register-format instructions write the result to register rd (bits [15:11]) at the closing edge. The function code (bits [5:0]) selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed set-on-less-than (result 1 or 0). Any other function code writes nothing.
- R7: Register 0 always reads as zero, and any write to it is discarded.
- R8: Word load writes data memory word (rs + sign-extended offset)/4 into register rt. Word store writes register rt to that memory word and writes no register.
- R9: Both register reads happen in the same cycle as one write. An instruction sees a value written by the instruction just before it.
- R10: `dbg_alu` shows the current ALU result. `dbg_wb` shows the loaded memory word for a load and the ALU result otherwise. `dbg_instr` shows the word at the current PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also enables the load port |
| load_en | input | 1 | Load port write strobe (effective only in reset) |
| load_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| load_addr | input | 8 | Word address for the load port |
| load_data | input | 32 | Word written by the load port |
| dbg_pc | output | 10 | Current byte program counter |
| dbg_instr | output | 32 | Instruction word at the current PC |
| dbg_alu | output | 32 | ALU result of the current instruction |
| dbg_wb | output | 32 | Value selected for register write-back |

## Verification
Every debug output is a combinational function of the current PC, the registers and the memories. An instruction's ALU result, write-back value and instruction word are therefore valid for the whole cycle in which it is current. Its effects on the PC, the registers and data memory land on the next rising edge and appear in the following cycle. The bench drives inputs and samples outputs at the falling edge. It checks each instruction's own results in the half cycle before that instruction's closing edge. It checks register and memory effects one instruction later, through an add, a load or the resulting PC.

// File: rtl/onecycle_pkg.sv
// onecycle_pkg: shared encodings and the control word for the single-cycle core.
// Assumes the fixed 32-bit instruction layout: opcode [31:26], funct [5:0].
package onecycle_pkg;

    localparam logic [5:0] OPC_RFMT  = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BREQ  = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;   // write a register at the closing edge
        logic    dst_is_rd;   // 1: destination rd, 0: destination rt
        logic    use_imm;     // ALU operand B from the sign-extended offset
        logic    mem_write;   // store to data memory
        logic    wb_from_mem; // write-back value from data memory
        logic    branch;      // branch-if-equal
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/oc_decode.sv
// oc_decode: main opcode decoder and ALU-operation decoder in one block.
// Assumes the opcode and function fields come straight from the current
// instruction; unknown opcodes and function codes produce an idle control word.
module oc_decode
    import onecycle_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Purpose: map the function code of a register-format instruction to an ALU op.
    logic    fn_ok;
    alu_op_e fn_op;
    always_comb begin
        fn_ok = 1'b1;
        unique case (funct)
            FN_ADD:  fn_op = OP_ADD;
            FN_SUB:  fn_op = OP_SUB;
            FN_AND:  fn_op = OP_AND;
            FN_OR:   fn_op = OP_OR;
            FN_SLT:  fn_op = OP_SLT;
            default: begin
                fn_op = OP_ADD;
                fn_ok = 1'b0;
            end
        endcase
    end

    // Purpose: build the control word from the opcode class.
    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_is_rd: 1'b0, use_imm: 1'b0, mem_write: 1'b0,
                 wb_from_mem: 1'b0, branch: 1'b0, alu_op: OP_ADD};
        unique case (opcode)
            OPC_RFMT: begin
                ctrl.reg_write = fn_ok;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_op    = fn_op;
            end
            OPC_LOAD: begin
                ctrl.reg_write   = 1'b1;
                ctrl.use_imm     = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.use_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BREQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = OP_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/oc_regfile.sv
// oc_regfile: register bank with two combinational read ports and one write port.
// Assumes writes land at the rising edge; entry 0 is a constant zero and never stored.
module oc_regfile #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);

    localparam int NREGS = 1 << AW;

    logic [DW-1:0] bank [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign bank[i] = '0;
        end else begin : g_store
            logic [DW-1:0] q;
            // Purpose: hold one register, cleared by reset, loaded when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)                      q <= '0;
                else if (we && wa == AW'(i))     q <= wd;
            end
            assign bank[i] = q;
        end
    end

    assign rd_a = bank[ra_a];
    assign rd_b = bank[ra_b];

endmodule

// File: rtl/oc_alu.sv
// oc_alu: 32-bit arithmetic/logic unit with a zero flag.
// Assumes two's-complement operands; set-on-less-than compares signed.
module oc_alu
    import onecycle_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y,
    output logic          zero
);

    // Purpose: select the result of the requested operation.
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_SLT:  y = DW'($signed(a) < $signed(b));
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/oc_datamem.sv
// oc_datamem: word-organised data store, synchronous write, combinational read.
// Assumes the caller has already chosen between the core and the load port.
module oc_datamem #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);

    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // Purpose: store one word at the rising edge when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wd;
    end

    assign rd = mem[addr];

endmodule

// File: rtl/onecycle_cpu.sv
// onecycle_cpu: single-cycle core running register-format ALU ops, word load,
// word store and branch-if-equal, one instruction per clock.
// Assumes programs and data are loaded through the load port while rst_n is low;
// the PC is a word address, reported as a byte address on dbg_pc.
module onecycle_cpu
    import onecycle_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 8,
    parameter int REG_AW  = 5
) (
    input  logic                                                 clk,
    input  logic                                                 rst_n,
    input  logic                                                 load_en,
    input  logic                                                 load_dmem,
    input  logic [((IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW)-1:0] load_addr,
    input  logic [DATA_W-1:0]                                    load_data,
    output logic [IMEM_AW+1:0]                                   dbg_pc,
    output logic [DATA_W-1:0]                                    dbg_instr,
    output logic [DATA_W-1:0]                                    dbg_alu,
    output logic [DATA_W-1:0]                                    dbg_wb
);

    localparam int IWORDS = 1 << IMEM_AW;
    localparam int IMM_W  = 16;

    // ---------------- fetch ----------------
    logic [IMEM_AW-1:0] pc_q;
    logic [IMEM_AW-1:0] pc_inc;
    logic [IMEM_AW-1:0] pc_tgt;
    logic [DATA_W-1:0]  imem [IWORDS];
    logic [DATA_W-1:0]  instr;

    // Purpose: accept program words from the load port while the core is in reset.
    always_ff @(posedge clk) begin
        if (!rst_n && load_en && !load_dmem)
            imem[load_addr[IMEM_AW-1:0]] <= load_data;
    end

    assign instr = imem[pc_q];

    // ---------------- decode ----------------
    logic [5:0]        opcode;
    logic [REG_AW-1:0] f_rs, f_rt, f_rd;
    logic [DATA_W-1:0] imm_ext;
    ctrl_t             ctrl;

    assign opcode  = instr[31:26];
    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign imm_ext = {{(DATA_W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    oc_decode u_dec (
        .opcode (opcode),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    // ---------------- registers ----------------
    logic [DATA_W-1:0] rs_val, rt_val, wb_val;
    logic [REG_AW-1:0] dst;

    assign dst = ctrl.dst_is_rd ? f_rd : f_rt;

    oc_regfile #(.DW(DATA_W), .AW(REG_AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (f_rs),
        .ra_b  (f_rt),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .we    (ctrl.reg_write),
        .wa    (dst),
        .wd    (wb_val)
    );

    // ---------------- execute ----------------
    logic [DATA_W-1:0] alu_y;
    logic              alu_zero;

    oc_alu #(.DW(DATA_W)) u_alu (
        .a    (rs_val),
        .b    (ctrl.use_imm ? imm_ext : rt_val),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // ---------------- memory ----------------
    logic               dm_we;
    logic               ld_dm;
    logic [DMEM_AW-1:0] dm_addr;
    logic [DATA_W-1:0]  dm_wd, dm_rd;

    assign ld_dm   = !rst_n && load_en && load_dmem;
    assign dm_we   = ld_dm || (rst_n && ctrl.mem_write);
    assign dm_addr = ld_dm ? load_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
    assign dm_wd   = ld_dm ? load_data : rt_val;

    oc_datamem #(.DW(DATA_W), .AW(DMEM_AW)) u_dm (
        .clk  (clk),
        .we   (dm_we),
        .addr (dm_addr),
        .wd   (dm_wd),
        .rd   (dm_rd)
    );

    // ---------------- write-back and next PC ----------------
    logic taken;

    assign wb_val = ctrl.wb_from_mem ? dm_rd : alu_y;
    assign taken  = ctrl.branch && alu_zero;
    assign pc_inc = pc_q + IMEM_AW'(1);
    assign pc_tgt = pc_inc + imm_ext[IMEM_AW-1:0];

    // Purpose: load the next word PC, or zero during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= taken ? pc_tgt : pc_inc;
    end

    assign dbg_pc    = {pc_q, 2'b00};
    assign dbg_instr = instr;
    assign dbg_alu   = alu_y;
    assign dbg_wb    = wb_val;

    // ---------------- assertions ----------------
    a_r1_reset_pc: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0));

    a_r2_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.branch && rs_val == rt_val) |=> (pc_q == $past(pc_q) + IMEM_AW'(1)));

    a_r5_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_BREQ && rs_val == rt_val)
            |=> (pc_q == $past(pc_q) + IMEM_AW'(1) + $past(instr[IMEM_AW-1:0])));

    a_r4_unknown_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OPC_RFMT && opcode != OPC_LOAD && opcode != OPC_STORE && opcode != OPC_BREQ)
            |-> (!ctrl.reg_write && !ctrl.mem_write && !ctrl.branch));

    a_r8_store_no_regwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_STORE) |-> (dm_we && !ctrl.reg_write));

    a_r7_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (f_rs == '0) |-> (rs_val == '0));

    a_r6_slt_bool: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_RFMT && instr[5:0] == FN_SLT) |-> (alu_y[DATA_W-1:1] == '0));

endmodule

// File: tb/onecycle_cpu_test.sv
`timescale 1ns/1ps
module onecycle_cpu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic        load_dmem = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [9:0]  dbg_pc;
    logic [31:0] dbg_instr, dbg_alu, dbg_wb;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    onecycle_cpu uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_dmem(load_dmem),
        .load_addr(load_addr), .load_data(load_data),
        .dbg_pc(dbg_pc), .dbg_instr(dbg_instr), .dbg_alu(dbg_alu), .dbg_wb(dbg_wb)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    localparam logic [5:0] ADD = 6'b100000, SUB = 6'b100010, AND_ = 6'b100100,
                           OR_ = 6'b100101, SLT = 6'b101010;
    localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(bit dmem, int addr, logic [31:0] data);
        @(negedge clk);
        load_en = 1'b1; load_dmem = dmem; load_addr = addr[7:0]; load_data = data;
        @(posedge clk);
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0; load_en = 1'b0;
        @(posedge clk);
    endtask

    task automatic release_reset();
        @(negedge clk);
        load_en = 1'b0; rst_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Reset state, load port, load port ignored once running.
    task automatic t_reset_load();
        hold_reset();
        put(0, 0, enc_r(0, 0, 1, ADD));
        put(0, 1, enc_r(0, 0, 2, OR_));
        @(negedge clk); load_en = 1'b0;
        chk("R1 pc in reset", 32'(dbg_pc), 32'd0);
        chk("R3 loaded word 0", dbg_instr, enc_r(0, 0, 1, ADD));
        release_reset();
        chk("R1 pc after release", 32'(dbg_pc), 32'd0);
        load_en = 1'b1; load_dmem = 1'b0; load_addr = 8'd1; load_data = 32'hDEADBEEF;
        step();
        load_en = 1'b0;
        chk("R2 pc advance", 32'(dbg_pc), 32'd4);
        chk("R3 load ignored while running", dbg_instr, enc_r(0, 0, 2, OR_));
    endtask

    // Register-format operations and back-to-back dependencies.
    task automatic t_arith();
        hold_reset();
        put(1, 0, 32'd7);
        put(1, 1, 32'hFFFFFFFD);
        put(0, 0, enc_i(LW, 0, 1, 0));
        put(0, 1, enc_i(LW, 0, 2, 4));
        put(0, 2, enc_r(1, 2, 3, ADD));
        put(0, 3, enc_r(1, 2, 4, SUB));
        put(0, 4, enc_r(1, 2, 5, AND_));
        put(0, 5, enc_r(1, 2, 6, OR_));
        put(0, 6, enc_r(2, 1, 7, SLT));
        put(0, 7, enc_r(1, 2, 8, SLT));
        put(0, 8, enc_r(8, 7, 10, ADD));
        put(0, 9, {6'b0, 5'd1, 5'd1, 5'd11, 5'd0, 6'b000111});
        put(0, 10, enc_r(11, 0, 12, ADD));
        release_reset();
        chk("R8 load wb", dbg_wb, 32'd7);
        step();
        chk("R10 load alu addr", dbg_alu, 32'd4);
        chk("R8 load negative word", dbg_wb, 32'hFFFFFFFD);
        step();
        chk("R9 R6 add sees previous write", dbg_alu, 32'd4);
        chk("R10 wb equals alu", dbg_wb, 32'd4);
        step(); chk("R6 sub", dbg_alu, 32'd10);
        step(); chk("R6 and", dbg_alu, 32'd5);
        step(); chk("R6 or", dbg_alu, 32'hFFFFFFFF);
        step(); chk("R6 slt signed true", dbg_alu, 32'd1);
        step(); chk("R6 slt signed false", dbg_alu, 32'd0);
        step(); chk("R9 R6 rd written", dbg_alu, 32'd1);
        chk("R2 pc word 8", 32'(dbg_pc), 32'd32);
        step(); step();
        chk("R6 unknown funct no write", dbg_alu, 32'd0);
    endtask

    // Loads, stores, register 0, unknown opcode.
    task automatic t_mem();
        hold_reset();
        put(1, 0, 32'd8);
        put(1, 1, 32'hCAFEF00D);
        put(1, 5, 32'h20);
        put(0, 0, enc_i(LW, 0, 1, 0));
        put(0, 1, enc_i(SW, 1, 1, 12));
        put(0, 2, enc_i(LW, 0, 2, 20));
        put(0, 3, enc_r(1, 0, 3, ADD));
        put(0, 4, enc_r(1, 1, 0, ADD));
        put(0, 5, enc_r(0, 0, 4, ADD));
        put(0, 6, enc_i(LW, 0, 0, 4));
        put(0, 7, enc_r(0, 0, 5, OR_));
        put(0, 8, enc_i(LW, 1, 6, -4));
        put(0, 9, enc_i(6'b001000, 1, 7, 1));
        put(0, 10, enc_r(7, 0, 8, ADD));
        release_reset();
        step();
        chk("R8 store address", dbg_alu, 32'd20);
        step();
        chk("R8 load sees store", dbg_wb, 32'd8);
        step();
        chk("R8 store writes no register", dbg_alu, 32'd8);
        step();
        chk("R10 wb to r0", dbg_wb, 32'd16);
        step();
        chk("R7 r0 after alu write", dbg_alu, 32'd0);
        step(); step();
        chk("R7 r0 after load write", dbg_alu, 32'd0);
        step();
        chk("R8 negative offset addr", dbg_alu, 32'd4);
        chk("R8 negative offset data", dbg_wb, 32'hCAFEF00D);
        step(); step();
        chk("R4 unknown opcode pc", 32'(dbg_pc), 32'd40);
        chk("R4 unknown opcode no write", dbg_alu, 32'd0);
    endtask

    // Branches both ways, backward, and a self loop; then reset mid-run.
    task automatic t_branch();
        hold_reset();
        put(1, 0, 32'd5);
        put(1, 1, 32'd5);
        put(1, 2, 32'd6);
        put(0, 0, enc_i(LW, 0, 1, 0));
        put(0, 1, enc_i(LW, 0, 2, 4));
        put(0, 2, enc_i(LW, 0, 3, 8));
        put(0, 3, enc_i(BEQ, 1, 3, 5));
        put(0, 4, enc_i(BEQ, 1, 2, 3));
        put(0, 5, enc_r(1, 1, 9, ADD));
        put(0, 6, enc_r(1, 3, 4, ADD));
        put(0, 7, enc_i(BEQ, 0, 0, 8));
        put(0, 8, enc_i(BEQ, 0, 0, -3));
        put(0, 16, enc_r(2, 2, 5, ADD));
        put(0, 17, enc_r(9, 0, 6, ADD));
        put(0, 18, enc_i(BEQ, 0, 0, -1));
        release_reset();
        step(); step(); step();
        chk("R5 compare alu", dbg_alu, 32'hFFFFFFFF);
        step();
        chk("R5 not taken pc", 32'(dbg_pc), 32'd16);
        step();
        chk("R5 forward taken pc", 32'(dbg_pc), 32'd32);
        step();
        chk("R5 backward taken pc", 32'(dbg_pc), 32'd24);
        chk("R5 landed instr", dbg_alu, 32'd11);
        step(); step();
        chk("R5 far forward pc", 32'(dbg_pc), 32'd64);
        chk("R5 target instr", dbg_alu, 32'd10);
        step();
        chk("R5 skipped word wrote nothing", dbg_alu, 32'd0);
        step(); step();
        chk("R5 self loop pc", 32'(dbg_pc), 32'd72);
        step();
        chk("R5 self loop holds", 32'(dbg_pc), 32'd72);
        rst_n = 1'b0;
        step();
        chk("R1 mid-run reset pc", 32'(dbg_pc), 32'd0);
        chk("R1 R3 program kept", dbg_instr, enc_i(LW, 0, 1, 0));
    endtask

    initial begin
        t_reset_load();
        t_arith();
        t_mem();
        t_branch();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule